// File: doc/BRIEF.md
# Accumulator Saturation and Flag Unit

This block sits behind the accumulate stage of a multiply-accumulate datapath. Each command carries a wide 64-bit sum that is bound for one of four 48-bit accumulators. The block checks whether the sum fits the accumulator in the selected arithmetic mode and records an overflow. It can clamp the value to a mode-specific limit. It then computes the zero, negative, overflow and extension-overflow condition flags from the value it writes back. Each accumulator also has its own sticky overflow bit. Once that bit is set, every later flag evaluation on the same accumulator reports overflow again.

A single command completes in one clock. The updated accumulator value and its index come out one cycle after the command, with a one-cycle valid pulse. The flags and sticky bits update in that same cycle. The condition flags are cumulative: each one ORs in its new value unless the command asks for the flags to be cleared first. The overflow flag therefore lives across commands. An overflow left standing by an earlier command forces clamping on a later command even when that command's own sum fits.

Top module: `accsat_unit`

## Requirements
- R1: One cycle after `cmd_valid_i`, `res_valid_o` is high for one cycle, `res_idx_o` equals the command's `acc_sel_i`, and `res_acc_o`, the flags and the sticky bits show the command's result. With no command, all of these hold their values.
- R2: The mode encoding is 0 = signed integer, 1 = unsigned, 2 = fractional, 3 = handled as signed integer. In signed and fractional modes, overflow is detected when sum bits 63..47 are not all equal.
- R3: In unsigned mode, overflow is detected when any of sum bits 63..48 is 1.
- R4: Define the working overflow as (overflow flag after the optional clear) OR (detected overflow). In signed mode, when the working overflow and `clamp_en_i` are both 1, the result is 0x00007FFFFFFF if sum bit 63 is 0 and 0xFFFF80000000 if it is 1. In signed mode without clamping, the result is sum bits 47..0.
- R5: In fractional mode, when the working overflow and `clamp_en_i` are both 1, the result is 0x7FFFFFFFFFFF if sum bit 63 is 0 and 0x800000000000 if it is 1. Otherwise the result is sum bits 47..0.
- R6: In unsigned mode, when the working overflow and `clamp_en_i` are both 1, the result is 0 if the sum is greater than 2^53 and 0xFFFFFFFFFFFF otherwise. Otherwise the result is sum bits 47..0.
- R7: `clr_flags_i` clears overflow, zero, negative and extension-overflow before the command is evaluated. Without it, a standing overflow flag acts as the working overflow, so it sets the sticky bit and triggers clamping even when the sum fits.
- R8: The zero flag ORs in (result == 0). The negative flag ORs in (result != 0 and result bit 47 == 1).
- R9: The overflow flag becomes the working overflow OR the sticky bit of the selected accumulator, after that bit has been updated.
- R10: Extension-overflow ORs in a per-mode test on the result. In fractional mode, result bits 47..40 are not all equal. In signed mode, result bits 47..32 are not all equal. In unsigned mode, any of result bits 47..32 is 1.
- R11: `sticky_o[k]` is set when a command on accumulator k has a working overflow of 1. Bit position k equals the accumulator index. Sticky bits are cleared only by reset, and reset also clears every flag and output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid_i | input | 1 | Command strobe |
| acc_sel_i | input | 2 | Accumulator index |
| mode_i | input | 2 | Arithmetic mode (0 signed, 1 unsigned, 2 fractional, 3 signed) |
| clamp_en_i | input | 1 | Clamp on overflow |
| clr_flags_i | input | 1 | Clear condition flags before evaluation |
| sum_i | input | 64 | Wide sum to be fitted into the accumulator |
| res_valid_o | output | 1 | Result strobe, one cycle after the command |
| res_idx_o | output | 2 | Accumulator index of the result |
| res_acc_o | output | 48 | Updated accumulator value |
| flag_v_o | output | 1 | Overflow flag |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag |
| flag_ev_o | output | 1 | Extension-overflow flag |
| sticky_o | output | 4 | Per-accumulator sticky overflow bits |

## Verification
The directed sums are chosen to separate behaviours that a narrower test would blur:
- A value of 2^32 sets extension-overflow in signed and unsigned modes but not in fractional mode.
- The pair 2^53 and 2^54 sits on the two sides of the unsigned clamp threshold.
- Sums just past the 48-bit range, positive and negative, tell the 32-bit integer clamp limit apart from the 48-bit fractional one.
- A small sum sent without a flag clear after an overflow shows a standing overflow forcing a clamp, while a cleared command on a sticky accumulator shows overflow coming back from the sticky bit.

The random commands then mix zero, sign-extended small values, values near the 48-bit edges and full 64-bit values, across all modes, indices, clamp settings and clear settings.

// File: rtl/accsat_pkg.sv
package accsat_pkg;
  typedef enum logic [1:0] {
    SM_SIGNED   = 2'd0,
    SM_UNSIGNED = 2'd1,
    SM_FRACT    = 2'd2,
    SM_SIGNED_B = 2'd3
  } sat_mode_e;
endpackage

// File: rtl/accsat_clamp.sv
module accsat_clamp
  import accsat_pkg::*;
#(
  parameter int SUM_W     = 64,
  parameter int ACC_W     = 48,
  parameter int INT_W     = 32,
  parameter int UWRAP_EXP = 53
) (
  input  sat_mode_e         mode_i,
  input  logic              clamp_en_i,
  input  logic              v_pre_i,
  input  logic [SUM_W-1:0]  sum_i,
  output logic              v_work_o,
  output logic [ACC_W-1:0]  result_o
);
  localparam logic [ACC_W-1:0] INT_POS  = {{(ACC_W-INT_W+1){1'b0}}, {(INT_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] INT_NEG  = ~INT_POS;
  localparam logic [ACC_W-1:0] FRAC_POS = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] FRAC_NEG = ~FRAC_POS;
  localparam logic [ACC_W-1:0] UMAX     = {ACC_W{1'b1}};
  localparam logic [SUM_W-1:0] U_THRESH = SUM_W'(1) << UWRAP_EXP;

  logic [SUM_W-ACC_W:0] sext_hi;
  logic                 sext_bad;
  logic                 zext_bad;
  logic                 det;
  logic                 sum_neg;

  always_comb begin
    sext_hi  = sum_i[SUM_W-1:ACC_W-1];
    sext_bad = !((&sext_hi) || (~|sext_hi));
    zext_bad = |sum_i[SUM_W-1:ACC_W];
    sum_neg  = sum_i[SUM_W-1];
    det      = (mode_i == SM_UNSIGNED) ? zext_bad : sext_bad;
    v_work_o = v_pre_i | det;
    result_o = sum_i[ACC_W-1:0];
    if (v_work_o && clamp_en_i) begin
      unique case (mode_i)
        SM_UNSIGNED: result_o = (sum_i > U_THRESH) ? '0 : UMAX;
        SM_FRACT:    result_o = sum_neg ? FRAC_NEG : FRAC_POS;
        default:     result_o = sum_neg ? INT_NEG : INT_POS;
      endcase
    end
  end
endmodule

// File: rtl/accsat_flags.sv
module accsat_flags
  import accsat_pkg::*;
#(
  parameter int ACC_W    = 48,
  parameter int INT_W    = 32,
  parameter int FRAC_EXT = 40
) (
  input  sat_mode_e        mode_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic             z_o,
  output logic             n_o,
  output logic             ev_o
);
  logic [ACC_W-FRAC_EXT-1:0] frac_seg;
  logic [ACC_W-INT_W-1:0]    int_seg;

  always_comb begin
    frac_seg = acc_i[ACC_W-1:FRAC_EXT];
    int_seg  = acc_i[ACC_W-1:INT_W];
    z_o      = (acc_i == '0);
    n_o      = !z_o && acc_i[ACC_W-1];
    unique case (mode_i)
      SM_FRACT:    ev_o = !((&frac_seg) || (~|frac_seg));
      SM_UNSIGNED: ev_o = |int_seg;
      default:     ev_o = !((&int_seg) || (~|int_seg));
    endcase
  end
endmodule

// File: rtl/accsat_unit.sv
module accsat_unit
  import accsat_pkg::*;
#(
  parameter int NUM_ACC   = 4,
  parameter int SUM_W     = 64,
  parameter int ACC_W     = 48,
  parameter int INT_W     = 32,
  parameter int FRAC_EXT  = 40,
  parameter int UWRAP_EXP = 53,
  localparam int IDX_W    = $clog2(NUM_ACC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid_i,
  input  logic [IDX_W-1:0]   acc_sel_i,
  input  logic [1:0]         mode_i,
  input  logic               clamp_en_i,
  input  logic               clr_flags_i,
  input  logic [SUM_W-1:0]   sum_i,
  output logic               res_valid_o,
  output logic [IDX_W-1:0]   res_idx_o,
  output logic [ACC_W-1:0]   res_acc_o,
  output logic               flag_v_o,
  output logic               flag_z_o,
  output logic               flag_n_o,
  output logic               flag_ev_o,
  output logic [NUM_ACC-1:0] sticky_o
);
  // reset synchronizer: assert asynchronously, release on clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  sat_mode_e mode;
  assign mode = sat_mode_e'(mode_i);

  logic               v_q, z_q, n_q, ev_q;
  logic               v_d, z_d, n_d, ev_d;
  logic               v_pre, z_pre, n_pre, ev_pre;
  logic               v_work;
  logic               z_new, n_new, ev_new;
  logic [ACC_W-1:0]   res_d, res_q;
  logic [IDX_W-1:0]   idx_q;
  logic               rv_q;
  logic [NUM_ACC-1:0] stk_q, stk_set, stk_d;

  accsat_clamp #(
    .SUM_W(SUM_W), .ACC_W(ACC_W), .INT_W(INT_W), .UWRAP_EXP(UWRAP_EXP)
  ) u_clamp (
    .mode_i(mode), .clamp_en_i(clamp_en_i), .v_pre_i(v_pre),
    .sum_i(sum_i), .v_work_o(v_work), .result_o(res_d)
  );

  accsat_flags #(
    .ACC_W(ACC_W), .INT_W(INT_W), .FRAC_EXT(FRAC_EXT)
  ) u_flags (
    .mode_i(mode), .acc_i(res_d), .z_o(z_new), .n_o(n_new), .ev_o(ev_new)
  );

  // next-state
  always_comb begin
    v_pre   = clr_flags_i ? 1'b0 : v_q;
    z_pre   = clr_flags_i ? 1'b0 : z_q;
    n_pre   = clr_flags_i ? 1'b0 : n_q;
    ev_pre  = clr_flags_i ? 1'b0 : ev_q;
    stk_set = v_work ? (NUM_ACC'(1) << acc_sel_i) : '0;
    stk_d   = stk_q | stk_set;
    v_d     = v_work | stk_d[acc_sel_i];
    z_d     = z_pre | z_new;
    n_d     = n_pre | n_new;
    ev_d    = ev_pre | ev_new;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rv_q  <= 1'b0;
      idx_q <= '0;
      res_q <= '0;
      v_q   <= 1'b0;
      z_q   <= 1'b0;
      n_q   <= 1'b0;
      ev_q  <= 1'b0;
    end else begin
      rv_q <= cmd_valid_i;
      if (cmd_valid_i) begin
        idx_q <= acc_sel_i;
        res_q <= res_d;
        v_q   <= v_d;
        z_q   <= z_d;
        n_q   <= n_d;
        ev_q  <= ev_d;
      end
    end
  end

  for (genvar k = 0; k < NUM_ACC; k++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)                     stk_q[k] <= 1'b0;
      else if (cmd_valid_i && stk_set[k])  stk_q[k] <= 1'b1;
    end
  end

  assign res_valid_o = rv_q;
  assign res_idx_o   = idx_q;
  assign res_acc_o   = res_q;
  assign flag_v_o    = v_q;
  assign flag_z_o    = z_q;
  assign flag_n_o    = n_q;
  assign flag_ev_o   = ev_q;
  assign sticky_o    = stk_q;
endmodule

// File: rtl/accsat_chk.sv
module accsat_chk #(
  parameter int NUM_ACC = 4,
  parameter int SUM_W   = 64,
  parameter int ACC_W   = 48,
  parameter int INT_W   = 32,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid_i,
  input logic [IDX_W-1:0]   acc_sel_i,
  input logic [1:0]         mode_i,
  input logic               clamp_en_i,
  input logic               clr_flags_i,
  input logic [SUM_W-1:0]   sum_i,
  input logic               res_valid_o,
  input logic [IDX_W-1:0]   res_idx_o,
  input logic [ACC_W-1:0]   res_acc_o,
  input logic               flag_v_o,
  input logic               flag_z_o,
  input logic               flag_n_o,
  input logic               flag_ev_o,
  input logic [NUM_ACC-1:0] sticky_o
);
  localparam logic [ACC_W-1:0] IP = {{(ACC_W-INT_W+1){1'b0}}, {(INT_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] FP = {1'b0, {(ACC_W-1){1'b1}}};

  logic sx_bad, zx_bad, is_int;
  assign sx_bad = !((&sum_i[SUM_W-1:ACC_W-1]) || (~|sum_i[SUM_W-1:ACC_W-1]));
  assign zx_bad = |sum_i[SUM_W-1:ACC_W];
  assign is_int = (mode_i == 2'd0) || (mode_i == 2'd3);

  a_r1_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (res_valid_o == $past(cmd_valid_i)));

  a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid_i |=> $stable({res_acc_o, flag_v_o, flag_z_o, flag_n_o, flag_ev_o, sticky_o}));

  a_r2_signed_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && mode_i != 2'd1 && sx_bad) |=> (flag_v_o && sticky_o[$past(acc_sel_i)]));

  a_r3_unsigned_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && mode_i == 2'd1 && zx_bad) |=> (flag_v_o && sticky_o[$past(acc_sel_i)]));

  a_r4_int_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && is_int && clamp_en_i && sx_bad) |=> (res_acc_o == IP || res_acc_o == ~IP));

  a_r5_frac_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && mode_i == 2'd2 && clamp_en_i && sx_bad) |=> (res_acc_o == FP || res_acc_o == ~FP));

  a_r8_zn_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && clr_flags_i) |=> !(flag_z_o && flag_n_o));

  a_r9_sticky_reports: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> (!sticky_o[res_idx_o] || flag_v_o));

  a_r11_sticky_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sticky_o) & ~sticky_o) == '0));
endmodule

bind accsat_unit accsat_chk #(
  .NUM_ACC(NUM_ACC), .SUM_W(SUM_W), .ACC_W(ACC_W), .INT_W(INT_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cmd_valid_i(cmd_valid_i), .acc_sel_i(acc_sel_i),
  .mode_i(mode_i), .clamp_en_i(clamp_en_i), .clr_flags_i(clr_flags_i), .sum_i(sum_i),
  .res_valid_o(res_valid_o), .res_idx_o(res_idx_o), .res_acc_o(res_acc_o),
  .flag_v_o(flag_v_o), .flag_z_o(flag_z_o), .flag_n_o(flag_n_o),
  .flag_ev_o(flag_ev_o), .sticky_o(sticky_o)
);

// File: tb/tb_accsat_unit.sv
`timescale 1ns/1ps
module tb_accsat_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  acc_sel;
  logic [1:0]  mode;
  logic        clamp_en;
  logic        clr_flags;
  logic [63:0] sum;
  logic        res_valid;
  logic [1:0]  res_idx;
  logic [47:0] res_acc;
  logic        fv, fz, fn, fev;
  logic [3:0]  sticky;

  accsat_unit dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .acc_sel_i(acc_sel),
    .mode_i(mode), .clamp_en_i(clamp_en), .clr_flags_i(clr_flags), .sum_i(sum),
    .res_valid_o(res_valid), .res_idx_o(res_idx), .res_acc_o(res_acc),
    .flag_v_o(fv), .flag_z_o(fz), .flag_n_o(fn), .flag_ev_o(fev), .sticky_o(sticky)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // bench model state
  logic        m_v, m_z, m_n, m_ev;
  logic [3:0]  m_stk;
  logic [47:0] m_acc;
  logic [1:0]  m_idx;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_v = 0; m_z = 0; m_n = 0; m_ev = 0; m_stk = '0; m_acc = '0; m_idx = '0;
  endtask

  task automatic model_step(logic [1:0] s, logic [1:0] md, logic cl, logic clr, logic [63:0] x);
    logic v0, ovf, v1, zc, nc, evc;
    logic [47:0] r;
    v0 = clr ? 1'b0 : m_v;
    if (clr) begin m_z = 0; m_n = 0; m_ev = 0; end
    if (md == 2'd1) ovf = (x >= 64'h0001_0000_0000_0000);
    else ovf = ($signed(x) > $signed(64'h0000_7FFF_FFFF_FFFF)) ||
               ($signed(x) < $signed(64'hFFFF_8000_0000_0000));
    v1 = v0 | ovf;
    r = x[47:0];
    if (v1 && cl) begin
      if (md == 2'd1)      r = (x > 64'h0020_0000_0000_0000) ? 48'h0 : 48'hFFFF_FFFF_FFFF;
      else if (md == 2'd2) r = x[63] ? 48'h8000_0000_0000 : 48'h7FFF_FFFF_FFFF;
      else                 r = x[63] ? 48'hFFFF_8000_0000 : 48'h0000_7FFF_FFFF;
    end
    if (v1) m_stk[s] = 1'b1;
    m_v = v1 | m_stk[s];
    zc  = (r == 0);
    nc  = (r != 0) && r[47];
    if (md == 2'd2)      evc = !(r[47:40] == 8'h00 || r[47:40] == 8'hFF);
    else if (md == 2'd1) evc = (r[47:32] != 16'h0);
    else                 evc = !(r[47:32] == 16'h0 || r[47:32] == 16'hFFFF);
    m_z = m_z | zc; m_n = m_n | nc; m_ev = m_ev | evc;
    m_acc = r; m_idx = s;
  endtask

  task automatic check_state(string acc_tag, logic exp_valid);
    chk("R1", "res_valid", 64'(res_valid), 64'(exp_valid));
    chk("R1", "res_idx", 64'(res_idx), 64'(m_idx));
    chk(acc_tag, "res_acc", 64'(res_acc), 64'(m_acc));
    chk("R9", "flag_v", 64'(fv), 64'(m_v));
    chk("R8", "flag_z", 64'(fz), 64'(m_z));
    chk("R8", "flag_n", 64'(fn), 64'(m_n));
    chk("R10", "flag_ev", 64'(fev), 64'(m_ev));
    chk("R11", "sticky", 64'(sticky), 64'(m_stk));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 0; acc_sel = 0; mode = 0;
    clamp_en = 0; clr_flags = 0; sum = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_clear();
    check_state("R11", 1'b0);
  endtask

  // called at a negedge; result checked at the following negedge
  task automatic do_cmd(logic [1:0] s, logic [1:0] md, logic cl, logic clr, logic [63:0] x);
    string t;
    acc_sel = s; mode = md; clamp_en = cl; clr_flags = clr; sum = x; cmd_valid = 1'b1;
    model_step(s, md, cl, clr, x);
    @(negedge clk);
    cmd_valid = 1'b0;
    sum = ~x;
    t = (md == 2'd1) ? "R6" : (md == 2'd2) ? "R5" : "R4";
    check_state(t, 1'b1);
  endtask

  function automatic logic [63:0] rnd_sum();
    logic [63:0] v;
    v = {$urandom(), $urandom()};
    unique case ($urandom_range(0, 4))
      0: return 64'h0;
      1: return {{32{v[31]}}, v[31:0]};
      2: return {{16{v[47]}}, v[47:0]};
      3: return {{15{v[48]}}, v[48:0]};
      default: return v;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    do_reset();
    @(negedge clk);
    // R8 zero result, signed, cleared
    do_cmd(2'd0, 2'd0, 1'b0, 1'b1, 64'h0);
    // R1 idle: outputs hold, valid drops
    @(negedge clk);
    check_state("R1", 1'b0);
    // R8 negative small value
    do_cmd(2'd0, 2'd0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFB);
    // R10 2^32: EV in signed, not in fractional, EV in unsigned
    do_cmd(2'd0, 2'd0, 1'b0, 1'b1, 64'h0000_0001_0000_0000);
    do_cmd(2'd0, 2'd2, 1'b0, 1'b1, 64'h0000_0001_0000_0000);
    do_cmd(2'd0, 2'd1, 1'b0, 1'b1, 64'h0000_0000_FFFF_FFFF);
    do_cmd(2'd0, 2'd1, 1'b0, 1'b1, 64'h0000_0001_0000_0000);
    // R2 signed overflow without clamp, truncated
    do_cmd(2'd2, 2'd0, 1'b0, 1'b1, 64'h0000_8000_0000_0000);
    // R4 signed clamp both signs, mode 3 alias
    do_cmd(2'd2, 2'd0, 1'b1, 1'b1, 64'h0001_0000_0000_0000);
    do_cmd(2'd2, 2'd3, 1'b1, 1'b1, 64'hFFFE_0000_0000_0000);
    // R5 fractional clamp both signs
    do_cmd(2'd3, 2'd2, 1'b1, 1'b1, 64'h0001_0000_0000_0000);
    do_cmd(2'd3, 2'd2, 1'b1, 1'b1, 64'hFFFE_0000_0000_0000);
    // R3 / R6 unsigned: above 2^53, exactly 2^53, just over 48 bits, unclamped
    do_cmd(2'd0, 2'd1, 1'b1, 1'b1, 64'h0040_0000_0000_0000);
    do_cmd(2'd0, 2'd1, 1'b1, 1'b1, 64'h0020_0000_0000_0000);
    do_cmd(2'd0, 2'd1, 1'b1, 1'b1, 64'h0001_0000_0000_0000);
    do_cmd(2'd0, 2'd1, 1'b0, 1'b1, 64'h0001_0000_0000_0005);
    // R7 standing overflow (not cleared) clamps a fitting sum on fresh acc 1
    do_cmd(2'd1, 2'd0, 1'b1, 1'b0, 64'h3);
    // R9 cleared command on sticky acc 1 still reports overflow
    do_cmd(2'd1, 2'd0, 1'b0, 1'b1, 64'h3);
    // R11 reset clears sticky bits
    do_reset();
    @(negedge clk);
    for (int i = 0; i < 400; i++) begin
      do_cmd(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
             1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0), rnd_sum());
      if ((i % 50) == 49) do_reset();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule